// File: doc/BRIEF.md
# Video Memory Write Slot Sequencer

This block sits between the host data-port write path and three on-chip video memories: a byte-wide pattern RAM, a word-wide color RAM and a word-wide vertical-scroll RAM. Host writes enter a four-entry FIFO together with a timestamp that says from which cycle the word may be consumed. The sequencer does nothing until an external access slot strobe arrives. On each strobe it either services the oldest FIFO word or reports that the slot went unused.

A 4-bit code register selects the destination memory. An address register gives the location, and an 8-bit step register is added to the address after every completed write. Both are loaded by the host. A word bound for the byte-wide pattern RAM needs two slots. The first slot stores the high byte at the address. The second slot stores the low byte at the address with bit 0 flipped. Only then is the word removed from the FIFO and the address advanced.

The control is a two-state machine. `SEQ_WORD` is the normal state, in which the next slot services a whole word or the first byte of a pattern word. `SEQ_LOW_BYTE` means the head word has written its high byte and still owes its low byte. The transition `SEQ_WORD -> SEQ_LOW_BYTE` fires on a serviced slot with the pattern code. The transition `SEQ_LOW_BYTE -> SEQ_WORD` fires on the next serviced slot. Every other case stays in the current state. Memory write ports are registered, so a write appears on the cycle after the strobe edge and lasts one cycle.

Top module: `vram_slot_sequencer`

## Requirements
- R1: After reset the FIFO is empty, `host_stall` is low, and all write enables and `slot_unused` are low.
- R2: A slot with an empty FIFO, or with a head word whose ready cycle is greater than `cur_cycle`, raises `slot_unused` for one cycle and writes nothing. A head word that was not ready stays queued and is served by a later slot once `cur_cycle` reaches its ready cycle.
- R3: With code 1 (pattern write) in the `SEQ_WORD` state, a slot writes bits 15:8 of the head word to pattern address = address register. It does not pop the word and does not change the address.
- R4: The next serviced slot writes bits 7:0 of the same word to pattern address = address register XOR 1. It then pops the word and advances the address.
- R5: Code 3 (color write) writes the whole word to color index = address bits 6:1, which is (address/2) masked to 64 entries.
- R6: Code 5 (vertical-scroll write) uses index = address bits 6:1, which is (address/2) mod 64. The write happens only when the index is below 40. An out-of-range write is dropped, but the word is still popped and the address still advances.
- R7: After every completed word, the address increases by the step register, modulo 2^16. A code other than 1, 3 or 5 writes nothing, does not raise `slot_unused`, pops the word and advances the address.
- R8: Words are served in push order. `host_stall` is high while 4 words are held. A push while `host_stall` is high is discarded.
- R9: With `slot_strobe` low, no write enable and no `slot_unused` is raised on the next cycle, and queued words remain.
- R10: At most one of the three write enables is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_cycle | input | 16 | Current cycle stamp, compared with each word's ready cycle |
| wr_valid | input | 1 | Push a host word into the FIFO |
| wr_data | input | 16 | Host word |
| wr_ready_at | input | 16 | First cycle from which the word may be consumed |
| host_stall | output | 1 | FIFO holds 4 words; pushes are discarded |
| cmd_we | input | 1 | Load code and address registers |
| cmd_code | input | 4 | Destination code (1 pattern, 3 color, 5 vertical-scroll) |
| cmd_addr | input | 16 | Start address |
| inc_we | input | 1 | Load step register |
| inc_val | input | 8 | Address step per completed word |
| slot_strobe | input | 1 | External access slot is available this cycle |
| pat_we | output | 1 | Pattern RAM byte write enable |
| pat_addr | output | 16 | Pattern RAM byte address |
| pat_data | output | 8 | Pattern RAM byte |
| col_we | output | 1 | Color RAM write enable |
| col_addr | output | 6 | Color RAM word index |
| col_data | output | 16 | Color RAM word |
| vs_we | output | 1 | Vertical-scroll RAM write enable |
| vs_addr | output | 6 | Vertical-scroll RAM word index |
| vs_data | output | 16 | Vertical-scroll RAM word |
| slot_unused | output | 1 | The last slot found nothing to service |

## Verification
A machine stuck in `SEQ_LOW_BYTE` shows up on the very next pattern slot. The wrong byte, or the address with bit 0 flipped, appears on the pattern port one cycle after the strobe. A lost word or a missing pop shows up in the slot that follows. The wrong word then reaches a RAM, or `slot_unused` rises where data was still owed. A wrong FIFO count is seen through `host_stall` one cycle after the fourth push, and again when the fifth word is either dropped or wrongly served. Address-step faults are caught on the second word of each vector, whose index is predicted from the step register alone.

// File: rtl/vsq_pkg.sv
package vsq_pkg;

    localparam int VSQ_DATA_W = 16;
    localparam int VSQ_TS_W   = 16;

    typedef struct packed {
        logic [VSQ_DATA_W-1:0] value;
        logic [VSQ_TS_W-1:0]   ready_at;
    } vsq_entry_t;

    typedef enum logic [0:0] {
        SEQ_WORD,
        SEQ_LOW_BYTE
    } seq_state_t;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_UNUSED,
        ACT_PAT_HI,
        ACT_PAT_LO,
        ACT_COLOR,
        ACT_VSCROLL,
        ACT_SKIP
    } slot_act_t;

    localparam logic [3:0] CODE_PATTERN = 4'd1;
    localparam logic [3:0] CODE_COLOR   = 4'd3;
    localparam logic [3:0] CODE_VSCROLL = 4'd5;

endpackage

// File: rtl/vsq_fifo.sv
module vsq_fifo
    import vsq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  vsq_entry_t din,
    input  logic       pop,
    output vsq_entry_t head,
    output logic       empty,
    output logic       full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    vsq_entry_t         slots [DEPTH];
    logic [CNT_W-1:0]   count;
    logic               push_ok;
    logic               pop_ok;
    logic [CNT_W-1:0]   wr_idx;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign wr_idx  = count - CNT_W'(pop_ok);
    assign head    = slots[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[g] <= '0;
            end else if (push_ok && wr_idx == CNT_W'(g)) begin
                slots[g] <= din;
            end else if (pop_ok) begin
                if (g < DEPTH - 1) begin
                    slots[g] <= slots[(g < DEPTH - 1) ? g + 1 : g];
                end else begin
                    slots[g] <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/vsq_addr_unit.sv
module vsq_addr_unit #(
    parameter int ADDR_W    = 16,
    parameter int INC_W     = 8,
    parameter int CODE_W    = 4,
    parameter int COL_WORDS = 64,
    parameter int VS_WORDS  = 40,
    parameter int VS_SPAN   = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_we,
    input  logic [CODE_W-1:0]             cmd_code,
    input  logic [ADDR_W-1:0]             cmd_addr,
    input  logic                          inc_we,
    input  logic [INC_W-1:0]              inc_val,
    input  logic                          advance,
    output logic [CODE_W-1:0]             code,
    output logic [ADDR_W-1:0]             addr,
    output logic [$clog2(COL_WORDS)-1:0]  col_idx,
    output logic [$clog2(VS_SPAN)-1:0]    vs_idx,
    output logic                          vs_in_range
);
    localparam int COL_AW = $clog2(COL_WORDS);
    localparam int VS_AW  = $clog2(VS_SPAN);

    logic [INC_W-1:0] step;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
            addr <= '0;
            step <= '0;
        end else begin
            if (cmd_we) begin
                code <= cmd_code;
                addr <= cmd_addr;
            end else if (advance) begin
                addr <= addr + ADDR_W'(step);
            end
            if (inc_we) begin
                step <= inc_val;
            end
        end
    end

    assign col_idx     = addr[COL_AW:1];
    assign vs_idx      = addr[VS_AW:1];
    assign vs_in_range = ({1'b0, vs_idx} < (VS_AW + 1)'(VS_WORDS));

endmodule

// File: rtl/vsq_slot_fsm.sv
module vsq_slot_fsm
    import vsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_strobe,
    input  logic       head_avail,
    input  logic [3:0] code,
    output slot_act_t  act,
    output logic       pop,
    output logic       advance
);
    seq_state_t state, state_nxt;
    logic       serve;

    assign serve = slot_strobe && head_avail;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_WORD;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SEQ_WORD: begin
                if (serve && code == CODE_PATTERN) begin
                    state_nxt = SEQ_LOW_BYTE;
                end
            end
            SEQ_LOW_BYTE: begin
                if (serve) begin
                    state_nxt = SEQ_WORD;
                end
            end
            default: state_nxt = SEQ_WORD;
        endcase
    end

    always_comb begin
        act     = ACT_IDLE;
        pop     = 1'b0;
        advance = 1'b0;
        if (slot_strobe && !head_avail) begin
            act = ACT_UNUSED;
        end else if (serve) begin
            pop     = 1'b1;
            advance = 1'b1;
            unique case (code)
                CODE_PATTERN: begin
                    if (state == SEQ_LOW_BYTE) begin
                        act = ACT_PAT_LO;
                    end else begin
                        act     = ACT_PAT_HI;
                        pop     = 1'b0;
                        advance = 1'b0;
                    end
                end
                CODE_COLOR:   act = ACT_COLOR;
                CODE_VSCROLL: act = ACT_VSCROLL;
                default:      act = ACT_SKIP;
            endcase
        end
    end

endmodule

// File: rtl/vram_slot_sequencer.sv
module vram_slot_sequencer
    import vsq_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int ADDR_W    = 16,
    parameter int INC_W     = 8,
    parameter int COL_WORDS = 64,
    parameter int VS_WORDS  = 40,
    parameter int VS_SPAN   = 64,
    localparam int COL_AW   = $clog2(COL_WORDS),
    localparam int VS_AW    = $clog2(VS_SPAN),
    localparam int DATA_W   = VSQ_DATA_W,
    localparam int TS_W     = VSQ_TS_W,
    localparam int BYTE_W   = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   cur_cycle,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TS_W-1:0]   wr_ready_at,
    output logic              host_stall,
    input  logic              cmd_we,
    input  logic [3:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              inc_we,
    input  logic [INC_W-1:0]  inc_val,
    input  logic              slot_strobe,
    output logic              pat_we,
    output logic [ADDR_W-1:0] pat_addr,
    output logic [BYTE_W-1:0] pat_data,
    output logic              col_we,
    output logic [COL_AW-1:0] col_addr,
    output logic [DATA_W-1:0] col_data,
    output logic              vs_we,
    output logic [VS_AW-1:0]  vs_addr,
    output logic [DATA_W-1:0] vs_data,
    output logic              slot_unused
);
    vsq_entry_t        head;
    vsq_entry_t        push_word;
    logic              fifo_empty;
    logic              head_avail;
    logic              pop;
    logic              advance;
    slot_act_t         act;
    logic [3:0]        code;
    logic [ADDR_W-1:0] addr;
    logic [COL_AW-1:0] col_idx;
    logic [VS_AW-1:0]  vs_idx;
    logic              vs_in_range;

    assign push_word.value    = wr_data;
    assign push_word.ready_at = wr_ready_at;
    assign head_avail         = !fifo_empty && (head.ready_at <= cur_cycle);

    vsq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_valid),
        .din   (push_word),
        .pop   (pop),
        .head  (head),
        .empty (fifo_empty),
        .full  (host_stall)
    );

    vsq_addr_unit #(
        .ADDR_W    (ADDR_W),
        .INC_W     (INC_W),
        .CODE_W    (4),
        .COL_WORDS (COL_WORDS),
        .VS_WORDS  (VS_WORDS),
        .VS_SPAN   (VS_SPAN)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we      (cmd_we),
        .cmd_code    (cmd_code),
        .cmd_addr    (cmd_addr),
        .inc_we      (inc_we),
        .inc_val     (inc_val),
        .advance     (advance),
        .code        (code),
        .addr        (addr),
        .col_idx     (col_idx),
        .vs_idx      (vs_idx),
        .vs_in_range (vs_in_range)
    );

    vsq_slot_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_strobe (slot_strobe),
        .head_avail  (head_avail),
        .code        (code),
        .act         (act),
        .pop         (pop),
        .advance     (advance)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_we      <= 1'b0;
            pat_addr    <= '0;
            pat_data    <= '0;
            col_we      <= 1'b0;
            col_addr    <= '0;
            col_data    <= '0;
            vs_we       <= 1'b0;
            vs_addr     <= '0;
            vs_data     <= '0;
            slot_unused <= 1'b0;
        end else begin
            pat_we      <= (act == ACT_PAT_HI) || (act == ACT_PAT_LO);
            col_we      <= (act == ACT_COLOR);
            vs_we       <= (act == ACT_VSCROLL) && vs_in_range;
            slot_unused <= (act == ACT_UNUSED);
            if (act == ACT_PAT_HI) begin
                pat_addr <= addr;
                pat_data <= head.value[DATA_W-1:BYTE_W];
            end else if (act == ACT_PAT_LO) begin
                pat_addr <= addr ^ ADDR_W'(1);
                pat_data <= head.value[BYTE_W-1:0];
            end
            if (act == ACT_COLOR) begin
                col_addr <= col_idx;
                col_data <= head.value;
            end
            if (act == ACT_VSCROLL) begin
                vs_addr <= vs_idx;
                vs_data <= head.value;
            end
        end
    end

endmodule

// File: rtl/vsq_checker.sv
module vsq_checker #(
    parameter int COL_AW   = 6,
    parameter int VS_AW    = 6,
    parameter int VS_WORDS = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic             host_stall,
    input logic             slot_strobe,
    input logic             pat_we,
    input logic             col_we,
    input logic             vs_we,
    input logic [VS_AW-1:0] vs_addr,
    input logic             slot_unused
);
    AST_ONE_WRITE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pat_we, col_we, vs_we})); // R10

    AST_UNUSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_unused |-> !(pat_we || col_we || vs_we)); // R2

    AST_QUIET_WITHOUT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_strobe |=> !(pat_we || col_we || vs_we || slot_unused)); // R9

    AST_VS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vs_we |-> ({1'b0, vs_addr} < (VS_AW + 1)'(VS_WORDS))); // R6

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stall && wr_valid && !slot_strobe) |=> host_stall); // R8

endmodule

bind vram_slot_sequencer vsq_checker #(
    .COL_AW   (COL_AW),
    .VS_AW    (VS_AW),
    .VS_WORDS (VS_WORDS)
) u_vsq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .host_stall  (host_stall),
    .slot_strobe (slot_strobe),
    .pat_we      (pat_we),
    .col_we      (col_we),
    .vs_we       (vs_we),
    .vs_addr     (vs_addr),
    .slot_unused (slot_unused)
);

// File: tb/sim_vram_slot_sequencer.sv
module sim_vram_slot_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cur_cycle = '0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] wr_ready_at = '0;
    logic        host_stall;
    logic        cmd_we = 1'b0;
    logic [3:0]  cmd_code = '0;
    logic [15:0] cmd_addr = '0;
    logic        inc_we = 1'b0;
    logic [7:0]  inc_val = '0;
    logic        slot_strobe = 1'b0;
    logic        pat_we;
    logic [15:0] pat_addr;
    logic [7:0]  pat_data;
    logic        col_we;
    logic [5:0]  col_addr;
    logic [15:0] col_data;
    logic        vs_we;
    logic [5:0]  vs_addr;
    logic [15:0] vs_data;
    logic        slot_unused;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vram_slot_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .cur_cycle(cur_cycle),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready_at(wr_ready_at),
        .host_stall(host_stall), .cmd_we(cmd_we), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .inc_we(inc_we), .inc_val(inc_val),
        .slot_strobe(slot_strobe), .pat_we(pat_we), .pat_addr(pat_addr),
        .pat_data(pat_data), .col_we(col_we), .col_addr(col_addr),
        .col_data(col_data), .vs_we(vs_we), .vs_addr(vs_addr),
        .vs_data(vs_data), .slot_unused(slot_unused)
    );

    // Vector fields: [43:40] code, [39:24] start address, [23:16] step, [15:0] first word
    localparam logic [43:0] VECS [7] = '{
        {4'h1, 16'h1234, 8'd2,   16'hABCD},
        {4'h1, 16'hFFFF, 8'd1,   16'h5A3C},
        {4'h3, 16'h007E, 8'd2,   16'h0F0F},
        {4'h3, 16'h0100, 8'h80,  16'h7E81},
        {4'h5, 16'h004E, 8'd2,   16'h1111},
        {4'h5, 16'h00A0, 8'd0,   16'hC3C3},
        {4'hA, 16'h0010, 8'd4,   16'h9999}
    };

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic configure(input logic [3:0] code, input logic [15:0] addr, input logic [7:0] inc);
        cmd_we = 1'b1; cmd_code = code; cmd_addr = addr;
        inc_we = 1'b1; inc_val = inc;
        step();
        cmd_we = 1'b0; inc_we = 1'b0;
    endtask

    task automatic push(input logic [15:0] value, input logic [15:0] ready);
        wr_valid = 1'b1; wr_data = value; wr_ready_at = ready;
        step();
        wr_valid = 1'b0;
    endtask

    task automatic slot();
        slot_strobe = 1'b1;
        step();
        slot_strobe = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        check("R1 host_stall", int'(host_stall), 0);
        check("R1 enables", int'({pat_we, col_we, vs_we}), 0);
        check("R1 slot_unused", int'(slot_unused), 0);
        slot();
        check("R1 empty fifo gives unused slot", int'(slot_unused), 1);

        foreach (VECS[v]) begin
            logic [3:0]  code;
            logic [15:0] base;
            logic [7:0]  inc;
            logic [15:0] w0;
            code = VECS[v][43:40];
            base = VECS[v][39:24];
            inc  = VECS[v][23:16];
            w0   = VECS[v][15:0];
            configure(code, base, inc);
            push(w0, 16'd0);
            push(~w0, 16'd0);
            for (int k = 0; k < 2; k++) begin
                logic [15:0] a;
                logic [15:0] w;
                logic [5:0]  idx;
                a   = base + (k == 1 ? 16'(inc) : 16'd0);
                w   = (k == 1) ? ~w0 : w0;
                idx = a[6:1];
                slot();
                check("R10 single enable", int'($countones({pat_we, col_we, vs_we}) <= 1), 1);
                unique case (code)
                    4'h1: begin
                        check("R3 pat_we high byte", int'(pat_we), 1);
                        check(k == 1 ? "R7 pat_addr after step" : "R3 pat_addr", int'(pat_addr), int'(a));
                        check("R3 pat_data high", int'(pat_data), int'(w[15:8]));
                        slot();
                        check("R4 pat_we low byte", int'(pat_we), 1);
                        check("R4 pat_addr xor 1", int'(pat_addr), int'(a ^ 16'd1));
                        check("R4 pat_data low", int'(pat_data), int'(w[7:0]));
                    end
                    4'h3: begin
                        check("R5 col_we", int'(col_we), 1);
                        check(k == 1 ? "R7 col_addr after step" : "R5 col_addr", int'(col_addr), int'(idx));
                        check("R5 col_data", int'(col_data), int'(w));
                    end
                    4'h5: begin
                        check("R6 vs_we range", int'(vs_we), int'(idx < 6'd40));
                        if (idx < 6'd40) begin
                            check(k == 1 ? "R7 vs_addr after step" : "R6 vs_addr", int'(vs_addr), int'(idx));
                            check("R6 vs_data", int'(vs_data), int'(w));
                        end
                    end
                    default: begin
                        check("R7 other code writes nothing", int'({pat_we, col_we, vs_we}), 0);
                        check("R7 other code not unused", int'(slot_unused), 0);
                    end
                endcase
            end
            slot();
            check("R2 drained fifo unused", int'(slot_unused), 1);
        end

        // R2: head not yet ready
        configure(4'h3, 16'h0010, 8'd2);
        cur_cycle = 16'd100;
        push(16'h1357, 16'd150);
        slot();
        check("R2 not ready unused", int'(slot_unused), 1);
        check("R2 not ready no write", int'(col_we), 0);
        cur_cycle = 16'd150;
        slot();
        check("R2 ready word served", int'(col_we), 1);
        check("R2 ready word addr", int'(col_addr), 8);
        check("R2 ready word data", int'(col_data), 16'h1357);

        // R9: without a slot nothing is written and the word stays queued
        push(16'h2468, 16'd0);
        repeat (3) step();
        check("R9 idle enables", int'({pat_we, col_we, vs_we}), 0);
        check("R9 idle unused", int'(slot_unused), 0);
        slot();
        check("R9 queued word kept", int'(col_data), 16'h2468);
        check("R9 queued word addr", int'(col_addr), 9);

        // R8: fill to four, fifth push discarded, order kept
        configure(4'h3, 16'h0020, 8'd2);
        for (int i = 0; i < 4; i++) begin
            check("R8 no stall before full", int'(host_stall), 0);
            push(16'h0100 + 16'(i), 16'd0);
        end
        check("R8 stall when full", int'(host_stall), 1);
        push(16'hDEAD, 16'd0);
        check("R8 stall holds", int'(host_stall), 1);
        for (int i = 0; i < 4; i++) begin
            slot();
            check("R8 order data", int'(col_data), 16'h0100 + i);
            check("R8 order addr", int'(col_addr), 16 + i);
            check("R10 only color", int'({pat_we, vs_we}), 0);
        end
        check("R8 stall released", int'(host_stall), 0);
        slot();
        check("R8 fifth push dropped", int'(slot_unused), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule